// File: doc/BRIEF.md
# Bit-Level Receive FIFO with Selectable Fill Start

This block sits behind a bit-recovery stage. It takes a stream of received bits, each marked by a one-cycle valid strobe, and chooses when to begin storing them in a small bit-granular FIFO. Storing can start in three ways: when an external valid-data indication is high, after the fixed 16-bit pattern 2DD4h has been seen in the incoming stream, or at once. A fourth code never starts. Once storing has begun it goes on until software clears the fill enable.

An interrupt output rises when the number of stored bits reaches a programmed level. Stored bits are packed first-received-first, and a host pops them as 8-bit bytes through a read strobe. All settings come from a 16-bit command word, which is accepted only when its upper byte identifies this block.

Top module: `rx_sync_fifo`

## Requirements
- R1: After reset the low command byte is 85h: level 8, sync-pattern start, fill disabled, FIFO enabled. The bit count, `irq`, `ovf` and `filling` are all 0, and received bits are not stored.
- R2: A `cfg_wr` pulse loads `cfg_data[7:0]` only when `cfg_data[15:8]` is CEh. Any other upper byte leaves the settings unchanged.
- R3: In the low command byte, bits 7:4 are the interrupt level, bits 3:2 the start mode, bit 1 the fill enable and bit 0 the FIFO enable. With start mode 11 and fill enabled, every valid bit is stored, starting with the first one.
- R4: With start mode 00, bits are ignored until a valid bit arrives while `vdi` is high. That bit is stored, and every later valid bit is stored too, even after `vdi` falls.
- R5: With start mode 01, the last 16 valid bits are compared with 2DD4h, oldest bit in bit 15. The bits up to and including the matching bit are not stored. Storing starts with the next valid bit.
- R6: Start mode 10 never starts, so no bit is stored while it is selected and the block is searching.
- R7: `rd_data` holds the oldest 8 stored bits, with the earliest-received bit in bit 7. A `rd_en` pulse removes them only when at least 8 bits are stored. With fewer than 8 stored, `rd_en` has no effect.
- R8: `irq` is high exactly when the FIFO is enabled and the stored bit count is at or above the level. It falls as soon as a read takes the count below the level.
- R9: The FIFO holds 16 bits. A bit that arrives while it is full is dropped and sets `ovf`, which stays set until the FIFO is disabled.
- R10: Clearing the fill enable stops storing at once and lowers `filling`. Setting it again begins a fresh search that ignores any pattern bits seen before.
- R11: While the FIFO enable is 0, the FIFO is held empty, `ovf` is clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Command word write strobe |
| cfg_data | input | 16 | Command word |
| bit_vld | input | 1 | Received bit valid strobe |
| bit_in | input | 1 | Received bit |
| vdi | input | 1 | Valid-data indication from the receiver |
| rd_en | input | 1 | Pop one byte |
| rd_data | output | 8 | Oldest stored byte, earliest bit in bit 7 |
| byte_rdy | output | 1 | At least 8 bits stored |
| fill_lvl | output | 5 | Number of stored bits |
| irq | output | 1 | Level interrupt |
| ovf | output | 1 | Sticky overflow flag |
| filling | output | 1 | Start condition met, bits are being stored |

## Verification
If the start search goes wrong, `filling` and `fill_lvl` reveal it within one bit strobe: a missed sync match keeps them at 0, and a false start makes the count rise too early. A wrong write pointer or a wrong pop shift shows up as a corrupted byte on `rd_data` at the next read. The bench therefore compares every popped byte against a bit queue built from the bits it expects to be kept. A stale overflow or level state appears on `ovf` or `irq` in the cycle after the event that should have changed it.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int LVL_W = 4;

  typedef enum logic [1:0] {
    START_VDI    = 2'b00,
    START_SYNC   = 2'b01,
    START_NONE   = 2'b10,
    START_ALWAYS = 2'b11
  } start_mode_e;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    start_mode_e      mode;
    logic             fill_en;
    logic             fifo_en;
  } rx_cfg_t;

  typedef enum logic {
    S_SEARCH = 1'b0,
    S_FILL   = 1'b1
  } fill_state_e;
endpackage

// File: rtl/rsf_cfg_reg.sv
module rsf_cfg_reg
  import rsf_pkg::*;
#(
  parameter logic [7:0]  CMD_ID = 8'hCE,
  parameter logic [15:0] POR    = 16'hCE85
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [15:0]   cfg_data,
  output rx_cfg_t       cfg
);
  rx_cfg_t cfg_q, cfg_d;
  logic    load;

  always_comb begin
    load  = cfg_wr && (cfg_data[15:8] == CMD_ID);
    cfg_d = cfg_q;
    if (load) cfg_d = rx_cfg_t'(cfg_data[7:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= rx_cfg_t'(POR[7:0]);
    else if (load) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/rsf_start_det.sv
module rsf_start_det
  import rsf_pkg::*;
#(
  parameter int              SYNC_W   = 16,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 16'h2DD4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  start_mode_e mode,
  input  logic        bit_vld,
  input  logic        bit_in,
  input  logic        vdi,
  output logic        wr_en,
  output logic        filling
);
  fill_state_e       st_q, st_d;
  logic [SYNC_W-1:0] sh_q, sh_d, sh_cat;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    wr_en  = 1'b0;
    sh_cat = {sh_q[SYNC_W-2:0], bit_in};
    if (!arm) begin
      st_d = S_SEARCH;
      sh_d = '0;
    end else if (st_q == S_FILL) begin
      wr_en = bit_vld;
    end else if (bit_vld) begin
      case (mode)
        START_VDI: begin
          if (vdi) begin
            st_d  = S_FILL;
            wr_en = 1'b1;
          end
        end
        START_SYNC: begin
          sh_d = sh_cat;
          if (sh_cat == SYNC_PAT) st_d = S_FILL;
        end
        START_ALWAYS: begin
          st_d  = S_FILL;
          wr_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_SEARCH;
      sh_q <= '0;
    end else begin
      st_q <= st_d;
      sh_q <= sh_d;
    end
  end

  assign filling = (st_q == S_FILL);
endmodule

// File: rtl/rsf_bit_fifo.sv
module rsf_bit_fifo #(
  parameter int DEPTH = 16,
  parameter int RD_W  = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             rd_en,
  output logic [RD_W-1:0]  rd_data,
  output logic [CNT_W-1:0] cnt,
  output logic             byte_rdy,
  output logic             ovf
);
  logic [DEPTH-1:0] mem_q, mem_d, mem_b;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_b;
  logic             ovf_q, ovf_d;
  logic             pop, wr_ok;

  always_comb begin
    pop   = rd_en && (cnt_q >= CNT_W'(RD_W));
    mem_b = pop ? (mem_q >> RD_W) : mem_q;
    cnt_b = pop ? (cnt_q - CNT_W'(RD_W)) : cnt_q;
    wr_ok = wr_en && (cnt_b < CNT_W'(DEPTH));
    mem_d = mem_b;
    cnt_d = cnt_b;
    ovf_d = ovf_q;
    if (wr_ok) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == cnt_b) mem_d[i] = wr_bit;
      end
      cnt_d = cnt_b + 1'b1;
    end else if (wr_en) begin
      ovf_d = 1'b1;
    end
    if (clr) begin
      mem_d = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      mem_q <= mem_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar g = 0; g < RD_W; g++) begin : g_rd
    assign rd_data[RD_W-1-g] = mem_q[g];
  end

  assign cnt      = cnt_q;
  assign byte_rdy = (cnt_q >= CNT_W'(RD_W));
  assign ovf      = ovf_q;
endmodule

// File: rtl/rx_sync_fifo.sv
module rx_sync_fifo
  import rsf_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          RD_W     = 8,
  parameter int          SYNC_W   = 16,
  parameter logic [15:0] SYNC_PAT = 16'h2DD4,
  parameter logic [7:0]  CMD_ID   = 8'hCE,
  parameter logic [15:0] POR      = 16'hCE85,
  localparam int         CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [15:0]      cfg_data,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             vdi,
  input  logic             rd_en,
  output logic [RD_W-1:0]  rd_data,
  output logic             byte_rdy,
  output logic [CNT_W-1:0] fill_lvl,
  output logic             irq,
  output logic             ovf,
  output logic             filling
);
  rx_cfg_t     cfg;
  logic        cfg_fifo_en, cfg_fill_en, arm, wr_en;
  start_mode_e cfg_mode;

  rsf_cfg_reg #(.CMD_ID(CMD_ID), .POR(POR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .cfg(cfg)
  );

  assign cfg_fifo_en = cfg.fifo_en;
  assign cfg_fill_en = cfg.fill_en;
  assign cfg_mode    = cfg.mode;
  assign arm         = cfg_fifo_en && cfg_fill_en;

  rsf_start_det #(.SYNC_W(SYNC_W), .SYNC_PAT(SYNC_PAT[SYNC_W-1:0])) u_start (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(cfg_mode),
    .bit_vld(bit_vld), .bit_in(bit_in), .vdi(vdi),
    .wr_en(wr_en), .filling(filling)
  );

  rsf_bit_fifo #(.DEPTH(DEPTH), .RD_W(RD_W), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(!cfg_fifo_en),
    .wr_en(wr_en), .wr_bit(bit_in), .rd_en(rd_en),
    .rd_data(rd_data), .cnt(fill_lvl), .byte_rdy(byte_rdy), .ovf(ovf)
  );

  assign irq = cfg_fifo_en && (fill_lvl >= CNT_W'(cfg.lvl));
endmodule

// File: rtl/rsf_chk.sv
module rsf_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             fill_en,
  input logic [1:0]       mode,
  input logic             filling,
  input logic [CNT_W-1:0] fill_lvl,
  input logic             ovf,
  input logic             rd_en,
  input logic             byte_rdy
);
  // R9: overflow flag stays set while the FIFO is enabled
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && fifo_en) |=> ovf);

  // R9: count never exceeds the capacity
  a_r9_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lvl <= CNT_W'(DEPTH));

  // R11: a disabled FIFO is emptied and its overflow cleared
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (fill_lvl == '0 && !ovf));

  // R6: the reserved start code never stores while searching
  a_r6_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (!filling && mode == 2'b10) |=> (fill_lvl <= $past(fill_lvl)));

  // R5: pattern bits are not stored
  a_r5_sync_unstored: assert property (@(posedge clk) disable iff (!rst_n)
    (!filling && mode == 2'b01) |=> (fill_lvl <= $past(fill_lvl)));

  // R10: dropping the fill enable stops filling
  a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en |=> !filling);

  // R7: a read with fewer than a byte stored removes nothing
  a_r7_short_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !byte_rdy && fifo_en) |=> (fill_lvl >= $past(fill_lvl)));
endmodule

bind rx_sync_fifo rsf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en), .fill_en(cfg_fill_en),
  .mode(cfg_mode), .filling(filling), .fill_lvl(fill_lvl), .ovf(ovf),
  .rd_en(rd_en), .byte_rdy(byte_rdy)
);

// File: tb/rx_sync_fifo_tb.sv
module rx_sync_fifo_tb;
  localparam int CLK_P = 10;

  logic        clk, rst_n, cfg_wr, bit_vld, bit_in, vdi, rd_en;
  logic [15:0] cfg_data;
  logic [7:0]  rd_data;
  logic        byte_rdy, irq, ovf, filling;
  logic [4:0]  fill_lvl;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit exp_q[$];

  rx_sync_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .bit_vld(bit_vld), .bit_in(bit_in), .vdi(vdi), .rd_en(rd_en),
    .rd_data(rd_data), .byte_rdy(byte_rdy), .fill_lvl(fill_lvl),
    .irq(irq), .ovf(ovf), .filling(filling)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [15:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = w;
    @(negedge clk); cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  // driver: pushes each bit expected to be kept into the scoreboard queue
  task automatic send_bit(input bit b, input bit v, input bit keep);
    @(negedge clk); bit_vld = 1'b1; bit_in = b; vdi = v;
    if (keep) exp_q.push_back(b);
    @(negedge clk); bit_vld = 1'b0; vdi = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit vfirst, input bit keep);
    for (int i = 7; i >= 0; i--) send_bit(d[i], vfirst && (i == 7), keep);
  endtask

  // monitor: pops expected bits and compares the byte the design presents
  task automatic do_read(input string tag);
    logic [7:0] e;
    @(negedge clk); rd_en = 1'b1;
    for (int i = 0; i < 8; i++) e[7-i] = exp_q.pop_front();
    chk(byte_rdy === 1'b1, tag, byte_rdy, 1);
    chk(rd_data === e, tag, rd_data, e);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk_lvl(input string tag);
    chk(fill_lvl == exp_q.size(), tag, fill_lvl, exp_q.size());
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected < 100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_data = '0;
    bit_vld = 1'b0; bit_in = 1'b0; vdi = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(fill_lvl == 0 && !irq && !ovf && !filling, "R1 reset", {fill_lvl, irq, ovf, filling}, 0);
    send_byte(8'hA5, 1'b1, 1'b0);
    chk_lvl("R1 fill disabled at reset");
    // R2 foreign command id ignored
    cfg(16'hAB8F);
    send_byte(8'hFF, 1'b0, 1'b0);
    chk_lvl("R2 wrong id");
    chk(!filling, "R2 wrong id filling", filling, 0);
    // R3 always mode, R8 level 8
    cfg(16'hCE8F);
    send_byte(8'hA5, 1'b0, 1'b1);
    chk_lvl("R3 always stores");
    chk(irq === 1'b1, "R8 irq at level", irq, 1);
    do_read("R7 byte order");
    chk(irq === 1'b0, "R8 irq clears after read", irq, 0);
    // R8 level 3
    cfg(16'hCE3F);
    send_bit(1, 0, 1); send_bit(0, 0, 1);
    chk(irq === 1'b0, "R8 below level", irq, 0);
    send_bit(1, 0, 1);
    chk(irq === 1'b1, "R8 reaches level", irq, 1);
    for (int i = 0; i < 5; i++) send_bit((i == 0 || i == 1), 0, 1);
    do_read("R7 level-3 byte");
    // R7 short read ignored
    for (int i = 0; i < 4; i++) send_bit(1, 0, 1);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk_lvl("R7 short read ignored");
    send_bit(1, 0, 1); send_bit(0, 0, 1); send_bit(0, 0, 1); send_bit(0, 0, 1);
    do_read("R7 after short read");
    // R9 overflow
    cfg(16'hCE8F);
    send_byte(8'h12, 0, 1);
    send_byte(8'h34, 0, 1);
    send_bit(1, 0, 0);
    chk(ovf === 1'b1, "R9 overflow set", ovf, 1);
    chk_lvl("R9 full count");
    do_read("R9 first byte");
    do_read("R9 second byte");
    chk(ovf === 1'b1, "R9 overflow sticky", ovf, 1);
    send_bit(1, 0, 1); send_bit(1, 0, 1); send_bit(0, 0, 1);
    // R11 disable
    cfg(16'hCE8E);
    exp_q.delete();
    chk(fill_lvl == 0 && !ovf && !irq, "R11 disabled clear", {fill_lvl, ovf, irq}, 0);
    send_bit(1, 1, 0);
    chk_lvl("R11 no store while disabled");
    // R4 valid-data start
    cfg(16'hCE83);
    send_bit(1, 0, 0); send_bit(0, 0, 0); send_bit(1, 0, 0);
    chk_lvl("R4 waits for vdi");
    send_byte(8'h96, 1'b1, 1'b1);
    chk_lvl("R4 keeps filling after vdi drops");
    do_read("R4 byte");
    // R10 fill disable
    cfg(16'hCE81);
    chk(!filling, "R10 stop filling", filling, 0);
    send_bit(1, 1, 0);
    chk_lvl("R10 stopped");
    // R6 reserved start code
    cfg(16'hCE8B);
    send_byte(8'hFF, 1'b1, 1'b0);
    chk_lvl("R6 reserved no store");
    chk(!filling, "R6 never starts", filling, 0);
    // R5 sync start
    cfg(16'hCE85); cfg(16'hCE87);
    send_byte(8'hAA, 0, 0); send_byte(8'h2D, 0, 0); send_byte(8'hD4, 0, 0);
    chk(filling === 1'b1, "R5 match starts fill", filling, 1);
    chk_lvl("R5 sync bits not stored");
    send_byte(8'h3C, 0, 1);
    do_read("R5 byte after sync");
    // R10 re-arm needs a new match
    cfg(16'hCE85);
    send_byte(8'h11, 0, 0);
    chk_lvl("R10 no store when off");
    cfg(16'hCE87);
    send_byte(8'h3C, 0, 0);
    chk(!filling && fill_lvl == 0, "R10 fresh search", {filling, fill_lvl}, 0);
    send_byte(8'h2D, 0, 0); send_byte(8'hD4, 0, 0); send_byte(8'h5A, 0, 1);
    do_read("R10 byte after re-arm");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule